// File: doc/BRIEF.md
# Synchronization Status Byte Filter

This block qualifies the synchronization status code carried in the low nibble of the received S1 byte. Once per frame a one-cycle strobe presents the byte. The block tracks how many frames in a row have carried the same code. It accepts a code only when that code has been received unchanged in three consecutive frames. The accepted code is held on a 4-bit output, which processor-visible status logic reads.

When an accepted code replaces a different filtered value, a single-cycle change pulse is produced for interrupt status logic. A second check counts frames that do not complete a persistence run. When a whole window of 16 frames passes without a single frame qualifying, an unstable level is raised. That level clears at the next qualifying frame. A frame qualifies when its code equals the codes of the two frames before it. A code held steady for many frames therefore keeps restarting the window and never raises the alarm.

Top module: `sync_status_filter`

## Requirements
- R1: After reset, the filtered code is 0, the change pulse is low and the unstable level is low.
- R2: Only bits [3:0] of the S1 byte form the code; bits [7:4] do not affect any output.
- R3: The filtered code takes a new value only in the cycle after a strobed frame whose code equals the codes of the two preceding strobed frames. A differing code restarts the run count at one.
- R4: The change output is high for exactly the one cycle after a qualifying frame, and only if the accepted code differs from the previous filtered code.
- R5: The unstable level rises in the cycle after the 16th consecutive strobed frame that does not qualify, counted from reset or from the last qualifying frame.
- R6: The unstable level falls in the cycle after a qualifying frame.
- R7: Without the frame strobe, changes on the S1 byte leave all outputs unchanged and the change output low.
- R8: A code received unchanged in every frame never raises the unstable level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle strobe, one per received frame |
| s1_byte | input | 8 | Received S1 byte, sampled on the strobe |
| sync_code | output | 4 | Filtered synchronization status code |
| sync_change | output | 1 | One-cycle pulse when the filtered code updates |
| sync_unstable | output | 1 | High while no code has persisted within the window |

## Verification
Suppose the run count is off by one or fails to restart. The filtered code would then move one frame early or late, or it would accept a code that was never held for three frames. The bench compares the outputs after every strobe, so such a fault shows within one frame. A wrong window count shifts the rise of the unstable level away from the 16th non-qualifying frame. Directed sequences land on frames 15 and 16 so that this shift is visible. Leakage of the upper byte bits, or of byte activity between strobes, appears as spurious change pulses or code moves in the gap cycles.

// File: rtl/s1f_pkg.sv
package s1f_pkg;
  // Run length after one strobed frame: grows while the code repeats, saturating at cap.
  function automatic int run_step(bit have_prev, bit same, int run, int cap);
    if (have_prev && same) return (run >= cap) ? cap : run + 1;
    return 1;
  endfunction

  // Non-qualifying frame count after one more such frame, saturating at limit.
  function automatic int win_step(int win, int limit);
    return (win >= limit) ? limit : win + 1;
  endfunction
endpackage

// File: rtl/s1f_run_tracker.sv
module s1f_run_tracker #(
  parameter int CODE_W  = 4,
  parameter int PERSIST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic              qualify
);
  localparam int RUN_W = $clog2(PERSIST + 1);

  logic [CODE_W-1:0] last_code;
  logic              have_last;
  logic [RUN_W-1:0]  run_cnt;
  logic [RUN_W-1:0]  nxt_run;
  logic              same;

  always_comb begin
    same    = (code == last_code);
    nxt_run = RUN_W'(s1f_pkg::run_step(have_last, same, int'(run_cnt), PERSIST));
    qualify = tick && (int'(nxt_run) >= PERSIST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_code <= '0;
      have_last <= 1'b0;
      run_cnt   <= '0;
    end else if (tick) begin
      last_code <= code;
      have_last <= 1'b1;
      run_cnt   <= nxt_run;
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_cnt) <= PERSIST); // R3
  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && have_last && !same) |=> (run_cnt == RUN_W'(1))); // R3
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(run_cnt)); // R7
endmodule

// File: rtl/s1f_window_monitor.sv
module s1f_window_monitor #(
  parameter int WINDOW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic qualify,
  output logic unstable
);
  localparam int WIN_W = $clog2(WINDOW + 1);

  logic [WIN_W-1:0] win_cnt;
  logic [WIN_W-1:0] win_nxt;
  logic             win_full;

  always_comb begin
    win_nxt  = WIN_W'(s1f_pkg::win_step(int'(win_cnt), WINDOW));
    win_full = (int'(win_nxt) == WINDOW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      unstable <= 1'b0;
    end else if (tick) begin
      if (qualify) begin
        win_cnt  <= '0;
        unstable <= 1'b0;
      end else begin
        win_cnt  <= win_nxt;
        if (win_full) unstable <= 1'b1;
      end
    end
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(win_cnt) <= WINDOW); // R5
  AST_ALARM_RISE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unstable) |-> int'(win_cnt) == WINDOW); // R5
  AST_ALARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    qualify |=> !unstable); // R6
endmodule

// File: rtl/s1f_filter_reg.sv
module s1f_filter_reg #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qualify,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] filt_code,
  output logic              change
);
  logic differs;

  always_comb differs = (code != filt_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_code <= '0;
      change    <= 1'b0;
    end else begin
      change <= qualify && differs;
      if (qualify && differs) filt_code <= code;
    end
  end

  AST_CHG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    change |=> !change); // R4
  AST_CHG_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    change |-> (filt_code != $past(filt_code))); // R4
  AST_HOLD_NO_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !qualify |=> $stable(filt_code)); // R3
endmodule

// File: rtl/sync_status_filter.sv
module sync_status_filter #(
  parameter int S1_W    = 8,
  parameter int CODE_W  = 4,
  parameter int PERSIST = 3,
  parameter int WINDOW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic [S1_W-1:0]   s1_byte,
  output logic [CODE_W-1:0] sync_code,
  output logic              sync_change,
  output logic              sync_unstable
);
  logic [CODE_W-1:0] rx_code;
  logic              frame_qualify;

  always_comb rx_code = s1_byte[CODE_W-1:0];

  s1f_run_tracker #(.CODE_W(CODE_W), .PERSIST(PERSIST)) u_run (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick), .code(rx_code),
    .qualify(frame_qualify)
  );

  s1f_window_monitor #(.WINDOW(WINDOW)) u_win (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick), .qualify(frame_qualify),
    .unstable(sync_unstable)
  );

  s1f_filter_reg #(.CODE_W(CODE_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .qualify(frame_qualify), .code(rx_code),
    .filt_code(sync_code), .change(sync_change)
  );

  AST_QUAL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    frame_qualify |-> frame_tick); // R7
  AST_CODE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ($stable(sync_code) && !sync_change)); // R7
endmodule

// File: tb/sync_status_filter_test.sv
module sync_status_filter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0;
  logic [7:0] s1_byte = 8'h00;
  logic [3:0] sync_code;
  logic       sync_change;
  logic       sync_unstable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  int m_last = 0, m_run = 0, m_win = 0, m_filt = 0;
  bit m_have = 0, m_alarm = 0, m_chg = 0;

  always #5 clk = ~clk;

  sync_status_filter uut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .s1_byte(s1_byte),
    .sync_code(sync_code), .sync_change(sync_change), .sync_unstable(sync_unstable)
  );

  function automatic int expect_run(bit have, int last, int code, int run);
    if (have && last == code) return (run < 3) ? run + 1 : 3;
    return 1;
  endfunction

  task automatic check(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_frame(int code);
    bit q;
    m_run  = expect_run(m_have, m_last, code, m_run);
    m_have = 1;
    m_last = code;
    q      = (m_run >= 3);
    m_chg  = q && (code != m_filt);
    if (m_chg) m_filt = code;
    if (q) begin
      m_win = 0; m_alarm = 0;
    end else begin
      m_win = (m_win < 16) ? m_win + 1 : 16;
      if (m_win == 16) m_alarm = 1;
    end
  endtask

  task automatic frame(int code, int upper, int gap);
    @(negedge clk);
    s1_byte    = 8'((upper << 4) | (code & 15));
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    model_frame(code & 15);
    check(int'(sync_code), m_filt, "R3 filtered code");
    check(int'(sync_change), int'(m_chg), "R4 change pulse");
    check(int'(sync_unstable), int'(m_alarm), "R5/R6 unstable level");
    for (int g = 0; g < gap; g++) begin
      s1_byte = 8'($urandom);
      @(negedge clk);
      check(int'(sync_code), m_filt, "R7 code held between strobes");
      check(int'(sync_change), 0, "R7 no pulse between strobes");
      check(int'(sync_unstable), int'(m_alarm), "R7 alarm held between strobes");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(sync_code), 0, "R1 reset code");
    check(int'(sync_change), 0, "R1 reset pulse");
    check(int'(sync_unstable), 0, "R1 reset alarm");

    // R3: two frames of 5 are not enough, the third accepts; R4 pulse
    frame(5, 0, 0);
    frame(5, 0, 0);
    check(int'(sync_code), 0, "R3 not yet accepted");
    frame(5, 0, 0);
    check(int'(sync_code), 5, "R3 accepted after three");
    check(int'(sync_change), 1, "R4 pulse on update");
    // R2: upper bits vary, code stays 5: no change pulse
    for (int i = 0; i < 4; i++) begin
      frame(5, i + 3, 1);
      check(int'(sync_change), 0, "R2 upper bits ignored");
    end
    // R8: steady code for 20 frames never alarms
    for (int i = 0; i < 20; i++) frame(5, i, 0);
    check(int'(sync_unstable), 0, "R8 steady code no alarm");
    // R5: alternating codes, alarm on 16th non-qualifying frame
    for (int i = 0; i < 15; i++) frame((i % 2) ? 9 : 3, 0, 0);
    check(int'(sync_unstable), 0, "R5 no alarm at 15");
    frame(3, 0, 0);
    check(int'(sync_unstable), 1, "R5 alarm at 16");
    // R6: three matching frames clear the alarm and move the code
    frame(7, 1, 0);
    frame(7, 2, 0);
    check(int'(sync_unstable), 1, "R6 alarm held before match");
    frame(7, 3, 0);
    check(int'(sync_unstable), 0, "R6 alarm cleared");
    check(int'(sync_code), 7, "R3 new code 7");
    // R7: long gap with busy byte
    frame(7, 0, 12);
    // random mix: repeat previous code often to form runs
    begin
      int code = 7;
      for (int i = 0; i < 400; i++) begin
        if ($urandom_range(0, 99) < 40) code = $urandom_range(0, 15);
        frame(code, $urandom_range(0, 15), $urandom_range(0, 3));
      end
    end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule